// File: doc/BRIEF.md
# Split-Path Floating-Point Adder/Subtractor

This block adds or subtracts two binary floating-point numbers and returns a correctly rounded result one clock later. The format is parameterised by exponent and fraction width and defaults to 32-bit single precision. Operand B is negated first when the subtract control is high. The two operands are then ordered by magnitude, so the larger one sets the result sign and the reference exponent.

An effective subtraction is one where the operands, after any negation of B, have opposite signs. It is sent down one of two datapaths, chosen by how far apart the effective exponents are. When they differ by zero or one, the close datapath aligns by at most one bit. It subtracts, counts the leading zeros of the difference and shifts left to normalise. That shift is bounded so the exponent never falls below the smallest normal value, which leaves a subnormal result. When the exponents are further apart, the wide datapath aligns the smaller operand with a long right shift that keeps guard, round and sticky information. Its result then moves by at most one place. Effective additions always use the wide datapath.

A single round-to-nearest-even stage serves both datapaths. NaN and infinity operands bypass the arithmetic.

Top module: `nfp_addsub`

## Requirements
- R1: While `rst_n` is low, `result` is all zeros.
- R2: The operands and `subtract` sampled at a rising clock edge determine `result` immediately after that edge. A new operation can be issued on every cycle.
- R3: For an effective subtraction whose effective exponents differ by 0 or 1, `result` equals the exact difference rounded to nearest, ties to even. The effective exponent is the exponent field, or 1 when the field is 0.
- R4: For an effective subtraction whose effective exponents differ by 2 or more, `result` equals the exact difference rounded to nearest, ties to even. Bits shifted out during alignment still decide the rounding.
- R5: For an effective addition, `result` equals the exact sum rounded to nearest, ties to even. A carry out of the significand, whether from the addition or from rounding, increments the exponent. A rounded exponent at or above the all-ones code gives an infinity of the result's sign.
- R6: An effective subtraction whose exact result is zero gives +0 (all bits zero). Adding two zeros of the same sign gives a zero of that sign.
- R7: Subnormal operands (exponent field 0) take part with no hidden bit, at the scale of exponent field 1. A result below the normal range is written with exponent field 0 and no loss beyond rounding.
- R8: If either operand is a NaN, `result` is the quiet NaN with sign 0, exponent field all ones, top fraction bit 1 and every other fraction bit 0. A NaN has exponent field all ones and a nonzero fraction.
- R9: An infinity combined with a finite value gives that infinity, with its sign after the optional negation. Two infinities of opposite effective sign give the quiet NaN of R8. Two infinities of the same effective sign give that infinity.
- R10: `subtract`=1 inverts the sign of `op_b` before the operation and `subtract`=0 leaves it unchanged. Adding or subtracting a zero to a finite nonzero `op_a` returns `op_a` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | EXP_W+MAN_W+1 | First operand: sign, exponent field, fraction |
| op_b | input | EXP_W+MAN_W+1 | Second operand, same layout |
| subtract | input | 1 | 1 computes op_a - op_b, 0 computes op_a + op_b |
| result | output | EXP_W+MAN_W+1 | Registered rounded result |

## Verification
The assertions assume the operand and control pins are steady at every sampling edge and free of unknown values. They also assume a quiet NaN is always the fixed pattern of R8 and never a propagated payload. The bench drives every input at the falling edge from a complete sweep of a reduced 4-bit-exponent, 3-bit-fraction format. That sweep covers every encoding, NaN and infinity included, so the assertion antecedents are reached without stepping outside these assumptions. Expected results come from exact integer arithmetic in the bench, rounded there to nearest-even.

// File: rtl/nfp_pkg.sv
package nfp_pkg;
  localparam int unsigned NFP_SP_EXP_W = 8;
  localparam int unsigned NFP_SP_MAN_W = 23;

  typedef enum logic {
    PATH_FAR  = 1'b0,
    PATH_NEAR = 1'b1
  } nfp_path_e;
endpackage

// File: rtl/nfp_near_path.sv
module nfp_near_path #(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23
) (
  input  logic [MAN_W:0]   sig_big,
  input  logic [MAN_W:0]   sig_small,
  input  logic [EXP_W-1:0] exp_big,
  input  logic             diff_one,
  output logic [EXP_W:0]   n_exp,
  output logic [MAN_W:0]   n_sig,
  output logic             n_g,
  output logic             n_zero
);
  localparam int unsigned SW  = MAN_W + 1;
  localparam int unsigned DW  = SW + 1;
  localparam int unsigned LZW = $clog2(DW + 1);

  logic [DW-1:0]  x_ext, y_ext, dif, dif_n;
  logic [LZW-1:0] lz;
  logic [EXP_W:0] lz_ext, lim, sh;

  assign x_ext = {sig_big, 1'b0};
  assign y_ext = diff_one ? {1'b0, sig_small} : {sig_small, 1'b0};
  assign dif   = x_ext - y_ext;

  // leading-zero count; the highest set bit wins
  always_comb begin
    lz = LZW'(DW);
    for (int i = 0; i < DW; i++) begin
      if (dif[i]) lz = LZW'(DW - 1 - i);
    end
  end

  // clamp so the exponent stays at or above 1 (gradual underflow)
  assign lz_ext = (EXP_W+1)'(lz);
  assign lim    = {1'b0, exp_big} - 1'b1;
  assign sh     = (lz_ext > lim) ? lim : lz_ext;
  assign dif_n  = dif << sh;

  assign n_sig  = dif_n[DW-1:1];
  assign n_g    = dif_n[0];
  assign n_exp  = {1'b0, exp_big} - sh;
  assign n_zero = (dif == '0);
endmodule

// File: rtl/nfp_far_path.sv
module nfp_far_path #(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23
) (
  input  logic [MAN_W:0]   sig_big,
  input  logic [MAN_W:0]   sig_small,
  input  logic [EXP_W-1:0] exp_big,
  input  logic [EXP_W-1:0] diff,
  input  logic             eff_sub,
  output logic [EXP_W:0]   f_exp,
  output logic [MAN_W:0]   f_sig,
  output logic             f_g,
  output logic             f_s
);
  localparam int unsigned SW  = MAN_W + 1;
  localparam int unsigned CAP = SW + 2;
  localparam int unsigned SHW = $clog2(CAP + 1);
  localparam int unsigned AW  = SW + 3;

  logic [SHW-1:0]    shamt;
  logic [2*SW+1:0]   wide;
  logic [AW-1:0]     x_al, y_al;
  logic [AW:0]       z;

  // long alignment with everything beyond the round bit folded to sticky
  assign shamt = (32'(diff) > CAP) ? SHW'(CAP) : SHW'(diff);
  assign wide  = {sig_small, {(SW+2){1'b0}}} >> shamt;
  assign y_al  = {wide[2*SW+1:SW], |wide[SW-1:0]};
  assign x_al  = {sig_big, 3'b000};
  assign z     = eff_sub ? ({1'b0, x_al} - {1'b0, y_al})
                         : ({1'b0, x_al} + {1'b0, y_al});

  // at most one place of normalisation either way
  always_comb begin
    if (z[AW]) begin
      f_sig = z[AW:4];
      f_g   = z[3];
      f_s   = |z[2:0];
      f_exp = {1'b0, exp_big} + 1'b1;
    end else if (z[AW-1] || !eff_sub) begin
      f_sig = z[AW-1:3];
      f_g   = z[2];
      f_s   = |z[1:0];
      f_exp = {1'b0, exp_big};
    end else begin
      f_sig = z[AW-2:2];
      f_g   = z[1];
      f_s   = z[0];
      f_exp = {1'b0, exp_big} - 1'b1;
    end
  end
endmodule

// File: rtl/nfp_round.sv
module nfp_round #(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23
) (
  input  logic                   sign,
  input  logic [EXP_W:0]         exp_in,
  input  logic [MAN_W:0]         sig_in,
  input  logic                   g_in,
  input  logic                   s_in,
  output logic [EXP_W+MAN_W:0]   packed_out
);
  localparam int unsigned SW = MAN_W + 1;
  localparam logic [EXP_W:0] EXP_TOP = {1'b0, {EXP_W{1'b1}}};

  logic           inc, ovf;
  logic [SW:0]    sum;
  logic [MAN_W:0] sig_r;
  logic [EXP_W:0] exp_r;
  logic [EXP_W-1:0] field;

  assign inc = g_in & (s_in | sig_in[0]);
  assign sum = {1'b0, sig_in} + {{SW{1'b0}}, inc};

  always_comb begin
    if (sum[SW]) begin
      sig_r = sum[SW:1];
      exp_r = exp_in + 1'b1;
    end else begin
      sig_r = sum[SW-1:0];
      exp_r = exp_in;
    end
  end

  assign ovf   = (exp_r >= EXP_TOP);
  assign field = sig_r[MAN_W] ? exp_r[EXP_W-1:0] : '0;
  assign packed_out = ovf ? {sign, {EXP_W{1'b1}}, {MAN_W{1'b0}}}
                          : {sign, field, sig_r[MAN_W-1:0]};
endmodule

// File: rtl/nfp_addsub.sv
module nfp_addsub
  import nfp_pkg::*;
#(
  parameter int unsigned EXP_W = NFP_SP_EXP_W,
  parameter int unsigned MAN_W = NFP_SP_MAN_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [EXP_W+MAN_W:0]   op_a,
  input  logic [EXP_W+MAN_W:0]   op_b,
  input  logic                   subtract,
  output logic [EXP_W+MAN_W:0]   result
);
  localparam int unsigned N = EXP_W + MAN_W + 1;
  localparam logic [N-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic               sb_eff, swap, eff_sub, sign_big;
  logic               a_nan, b_nan, a_inf, b_inf;
  logic [N-2:0]       mag_big, mag_small;
  logic [EXP_W-1:0]   fe_big, fe_small, ee_big, ee_small, diff;
  logic [MAN_W:0]     sig_big, sig_small;
  nfp_path_e          path;

  logic [EXP_W:0]     n_exp, f_exp, r_exp;
  logic [MAN_W:0]     n_sig, f_sig, r_sig;
  logic               n_g, n_zero, f_g, f_s, r_g, r_s;
  logic [N-1:0]       rounded, res_d, res_q;

  // operand decode
  assign sb_eff = op_b[N-1] ^ subtract;
  assign a_nan  = (&op_a[N-2:MAN_W]) & (|op_a[MAN_W-1:0]);
  assign b_nan  = (&op_b[N-2:MAN_W]) & (|op_b[MAN_W-1:0]);
  assign a_inf  = (&op_a[N-2:MAN_W]) & ~(|op_a[MAN_W-1:0]);
  assign b_inf  = (&op_b[N-2:MAN_W]) & ~(|op_b[MAN_W-1:0]);

  // magnitude ordering
  assign swap      = op_b[N-2:0] > op_a[N-2:0];
  assign mag_big   = swap ? op_b[N-2:0] : op_a[N-2:0];
  assign mag_small = swap ? op_a[N-2:0] : op_b[N-2:0];
  assign sign_big  = swap ? sb_eff : op_a[N-1];
  assign eff_sub   = op_a[N-1] ^ sb_eff;

  assign fe_big    = mag_big[N-2:MAN_W];
  assign fe_small  = mag_small[N-2:MAN_W];
  assign ee_big    = (fe_big   == '0) ? EXP_W'(1) : fe_big;
  assign ee_small  = (fe_small == '0) ? EXP_W'(1) : fe_small;
  assign sig_big   = {|fe_big,   mag_big[MAN_W-1:0]};
  assign sig_small = {|fe_small, mag_small[MAN_W-1:0]};
  assign diff      = ee_big - ee_small;

  assign path = (eff_sub && (diff <= EXP_W'(1))) ? PATH_NEAR : PATH_FAR;

  nfp_near_path #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_near (
    .sig_big  (sig_big),
    .sig_small(sig_small),
    .exp_big  (ee_big),
    .diff_one (diff[0]),
    .n_exp    (n_exp),
    .n_sig    (n_sig),
    .n_g      (n_g),
    .n_zero   (n_zero)
  );

  nfp_far_path #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_far (
    .sig_big  (sig_big),
    .sig_small(sig_small),
    .exp_big  (ee_big),
    .diff     (diff),
    .eff_sub  (eff_sub),
    .f_exp    (f_exp),
    .f_sig    (f_sig),
    .f_g      (f_g),
    .f_s      (f_s)
  );

  // path selection
  always_comb begin
    if (path == PATH_NEAR) begin
      r_exp = n_exp;
      r_sig = n_sig;
      r_g   = n_g;
      r_s   = 1'b0;
    end else begin
      r_exp = f_exp;
      r_sig = f_sig;
      r_g   = f_g;
      r_s   = f_s;
    end
  end

  nfp_round #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_round (
    .sign      (sign_big),
    .exp_in    (r_exp),
    .sig_in    (r_sig),
    .g_in      (r_g),
    .s_in      (r_s),
    .packed_out(rounded)
  );

  // special values override the arithmetic
  always_comb begin
    res_d = rounded;
    if ((path == PATH_NEAR) && n_zero) res_d = '0;
    if (a_inf || b_inf) begin
      res_d = (a_inf && b_inf && eff_sub) ? QNAN
                                          : {sign_big, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    end
    if (a_nan || b_nan) res_d = QNAN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else        res_q <= res_d;
  end

  assign result = res_q;
endmodule

// File: rtl/nfp_addsub_chk.sv
module nfp_addsub_chk #(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [EXP_W+MAN_W:0] op_a,
  input logic [EXP_W+MAN_W:0] op_b,
  input logic                 subtract,
  input logic [EXP_W+MAN_W:0] result
);
  localparam int unsigned N = EXP_W + MAN_W + 1;
  localparam logic [N-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic a_top, b_top, a_nan, b_nan, a_inf, b_inf, b_zero, a_zero, opp;

  assign a_top  = &op_a[N-2:MAN_W];
  assign b_top  = &op_b[N-2:MAN_W];
  assign a_nan  = a_top & (|op_a[MAN_W-1:0]);
  assign b_nan  = b_top & (|op_b[MAN_W-1:0]);
  assign a_inf  = a_top & ~(|op_a[MAN_W-1:0]);
  assign b_inf  = b_top & ~(|op_b[MAN_W-1:0]);
  assign a_zero = (op_a[N-2:0] == '0);
  assign b_zero = (op_b[N-2:0] == '0);
  assign opp    = op_a[N-1] ^ op_b[N-1] ^ subtract;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (result == '0));  // R1

  AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (a_nan || b_nan) |=> (result == QNAN));  // R8

  AST_INF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (a_inf && !b_top) |=> (result == $past(op_a)));  // R9

  AST_CANCEL_POS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_top && (op_a[N-2:0] == op_b[N-2:0]) && opp) |=> (result == '0));  // R6

  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_top && !a_zero && b_zero) |=> (result == $past(op_a)));  // R10
endmodule

bind nfp_addsub nfp_addsub_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .op_a    (op_a),
  .op_b    (op_b),
  .subtract(subtract),
  .result  (result)
);

// File: tb/nfp_addsub_test.sv
module nfp_addsub_test;
  localparam int EW = 4;
  localparam int MW = 3;
  localparam int N  = EW + MW + 1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] op_a, op_b, result;
  logic         subtract;
  int           errors = 0;
  int           checks = 0;
  bit           done = 1'b0;

  always #2 clk = ~clk;

  nfp_addsub #(.EXP_W(EW), .MAN_W(MW)) uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_a    (op_a),
    .op_b    (op_b),
    .subtract(subtract),
    .result  (result)
  );

  // exact reference: values as integers in units of the smallest subnormal
  function automatic logic [N-1:0] ref_model(input logic [N-1:0] a, input logic [N-1:0] b,
                                             input logic s);
    int fea, fra, feb, frb, va, vb, v, m, p, sh, e, sg, rem, half;
    logic bs, sgn;
    fea = int'(a[6:3]); fra = int'(a[2:0]);
    feb = int'(b[6:3]); frb = int'(b[2:0]);
    bs  = b[7] ^ s;
    if ((fea == 15 && fra != 0) || (feb == 15 && frb != 0)) return 8'h7C;
    if (fea == 15 && feb == 15) return (a[7] != bs) ? 8'h7C : {a[7], 7'h78};
    if (fea == 15) return {a[7], 7'h78};
    if (feb == 15) return {bs, 7'h78};
    va = ((fea != 0) ? 8 + fra : fra) << (((fea == 0) ? 1 : fea) - 1);
    vb = ((feb != 0) ? 8 + frb : frb) << (((feb == 0) ? 1 : feb) - 1);
    v  = (a[7] ? -va : va) + (bs ? -vb : vb);
    if (v == 0) return (a[7] == bs) ? {a[7], 7'h00} : 8'h00;
    sgn = (v < 0);
    m   = sgn ? -v : v;
    if (m < 16) return {sgn, 4'(m >> 3), 3'(m & 7)};
    p = 0;
    for (int i = 0; i < 31; i++) if (((m >> i) & 1) == 1) p = i;
    sh   = p - 3;
    e    = sh + 1;
    sg   = m >> sh;
    rem  = m & ((1 << sh) - 1);
    half = 1 << (sh - 1);
    if (rem > half || (rem == half && (sg & 1) == 1)) sg = sg + 1;
    if (sg == 16) begin sg = 8; e = e + 1; end
    if (e >= 15) return {sgn, 7'h78};
    return {sgn, 4'(e), 3'(sg & 7)};
  endfunction

  // which requirement a vector exercises
  function automatic string tag_of(input logic [N-1:0] a, input logic [N-1:0] b,
                                   input logic s, input logic [N-1:0] r);
    string t;
    int eea, eeb, dd;
    logic bs;
    bs  = b[7] ^ s;
    eea = (a[6:3] == 0) ? 1 : int'(a[6:3]);
    eeb = (b[6:3] == 0) ? 1 : int'(b[6:3]);
    dd  = (eea > eeb) ? eea - eeb : eeb - eea;
    if ((a[6:3] == 15 && a[2:0] != 0) || (b[6:3] == 15 && b[2:0] != 0)) t = "R8";
    else if (a[6:3] == 15 || b[6:3] == 15)                              t = "R9";
    else if (r[6:0] == 0)                                               t = "R6";
    else if ((a[6:3] == 0 && a[2:0] != 0) || (b[6:3] == 0 && b[2:0] != 0) ||
             (r[6:3] == 0))                                             t = "R7";
    else if (a[7] == bs)                                                t = "R5";
    else if (dd <= 1)                                                   t = "R3";
    else                                                                t = "R4";
    if (s) t = {t, "/R10"};
    return {t, "/R2"};
  endfunction

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, got=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stimulus
    logic [N-1:0] pa, pb, pexp;
    logic         ps, have;
    rst_n = 1'b0;
    op_a = 8'h35; op_b = 8'h12; subtract = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (result !== 8'h00) begin
      errors++;
      $display("FAIL R1 reset: got=%h exp=00", result);
    end
    rst_n = 1'b1;
    have = 1'b0;
    pa = '0; pb = '0; ps = 1'b0; pexp = '0;
    for (int s = 0; s < 2; s++) begin
      for (int ia = 0; ia < 256; ia++) begin
        for (int ib = 0; ib < 256; ib++) begin
          @(negedge clk);
          if (have) begin
            checks++;
            if (result !== pexp) begin
              errors++;
              $display("FAIL %s a=%h b=%h sub=%0d got=%h exp=%h",
                       tag_of(pa, pb, ps, pexp), pa, pb, ps, result, pexp);
            end
          end
          pa = 8'(ia); pb = 8'(ib); ps = s[0];
          op_a = pa; op_b = pb; subtract = ps;
          pexp = ref_model(pa, pb, ps);
          have = 1'b1;
        end
      end
    end
    @(negedge clk);
    checks++;
    if (result !== pexp) begin
      errors++;
      $display("FAIL %s a=%h b=%h sub=%0d got=%h exp=%h",
               tag_of(pa, pb, ps, pexp), pa, pb, ps, result, pexp);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule